// File: doc/BRIEF.md
# Tagged Memory Access Checker

This block is a small byte-addressed data memory in which every 16-byte granule carries a 4-bit lock tag. Each access carries a key in the top byte of its 64-bit address. Before an ordinary load or store is allowed to complete, the block compares that key with the lock of the granule being addressed. A match lets the access proceed. A mismatch blocks the access and raises a fault flag in the response.

Dedicated operations read a granule's lock, set it, or set it and clear the granule's data. Two-granule variants of the set operations apply one lock to a granule and the one after it. A combined operation writes a lock and a data byte together. For every lock-setting operation, the new lock value is taken from the key field of the request address.

Requests are accepted on any cycle in which `req_valid` is high. The response appears in the following cycle. A global `check_en` input turns checking off entirely.

Top module: `tagchk_mem`

## Requirements
- R1: After reset every lock is 0, every data byte is 0 and `rsp_valid` is low, so loads carrying key 0 pass and return 0.
- R2: Operation codes on `req_op`:
  - 0 load
  - 1 store
  - 2 tag read
  - 3 tag set
  - 4 tag set with zeroing
  - 5 two-granule tag set
  - 6 two-granule tag set with zeroing
  - 7 tag-and-data store

  A request with `req_valid` high produces `rsp_valid` high in the next cycle, and `rsp_valid` is low otherwise. A store with a matching key writes `req_wdata` to the addressed byte. A load with a matching key returns that byte on `rsp_rdata` in the response cycle.
- R3: A load or store whose key differs from the granule's lock, with checking enabled, raises `rsp_fault` in its response cycle. A faulting load returns `rsp_rdata` = 0. A faulting store changes no data and no lock.
- R4: While `check_en` is low, loads and stores are performed regardless of key and `rsp_fault` stays low.
- R5: The address is decoded as follows:
  - Bits 59:56 hold the key.
  - Bits 3:0 select the byte within a granule.
  - Bits 4+GIDX_W-1:4 select the granule, with GIDX_W = 4 by default.
  - Bits 63:60 and all remaining bits of 55:0 are ignored.
- R6: A tag set (op 3) sets the addressed granule's lock to the address key and leaves its data unchanged.
- R7: A zeroing tag set (op 4) sets the lock and clears all 16 data bytes of the granule.
- R8: The two-granule forms (ops 5 and 6) act on granule g and granule (g+1) mod NUM_GRAN, each in the manner of its single-granule form.
- R9: A tag-and-data store (op 7) sets the granule's lock to the address key and writes `req_wdata` to the addressed byte, in one operation.
- R10: Tag operations (ops 2 to 7) are never checked and never fault. A tag read returns `rsp_addr` equal to the request address with bits 59:56 replaced by the granule's lock. Every other operation returns `rsp_addr` equal to the request address, and `rsp_rdata` is 0 for all operations other than load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| check_en | input | 1 | Enables key checking on loads and stores |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 64 | Address with key in bits 59:56 |
| req_wdata | input | 8 | Store data byte |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 8 | Load data, zero otherwise |
| rsp_addr | output | 64 | Echoed address; for tag read, lock inserted in key field |
| rsp_fault | output | 1 | Key/lock mismatch on a checked access |

## Verification
The properties assume that `req_op`, `req_addr` and `check_en` are stable and known whenever `req_valid` is high, and that a response is always consumed in the cycle it appears, since there is no back-pressure. The stimulus drives every request on the falling clock edge and holds it for a full cycle. It sweeps every byte of the default 16-granule memory with matching keys, mismatched keys and checking switched off. It also places two-granule operations on the last granule so that the wrap to granule 0 is exercised.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int ADDR_W  = 64;
  localparam int KEY_LSB = 56;
  localparam int KEY_W   = 4;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    OP_LOAD       = 3'd0,
    OP_STORE      = 3'd1,
    OP_TAG_RD     = 3'd2,
    OP_TAG_SET    = 3'd3,
    OP_TAG_SET_Z  = 3'd4,
    OP_TAG_SET2   = 3'd5,
    OP_TAG_SET_Z2 = 3'd6,
    OP_TAG_DATA   = 3'd7
  } op_e;

  function automatic logic op_is_data(op_e op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic op_sets_lock(op_e op);
    return (op == OP_TAG_SET) || (op == OP_TAG_SET_Z) || (op == OP_TAG_SET2) ||
           (op == OP_TAG_SET_Z2) || (op == OP_TAG_DATA);
  endfunction

  function automatic logic op_is_double(op_e op);
    return (op == OP_TAG_SET2) || (op == OP_TAG_SET_Z2);
  endfunction

  function automatic logic op_zeroes(op_e op);
    return (op == OP_TAG_SET_Z) || (op == OP_TAG_SET_Z2);
  endfunction
endpackage

// File: rtl/tmc_lock_store.sv
module tmc_lock_store #(
  parameter int NUM_GRAN = 16,
  parameter int KEY_W    = 4,
  localparam int GIDX_W  = $clog2(NUM_GRAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GIDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0]  rd_lock,
  input  logic              we,
  input  logic              we2,
  input  logic [GIDX_W-1:0] wr_idx,
  input  logic [GIDX_W-1:0] wr_idx2,
  input  logic [KEY_W-1:0]  wr_lock
);
  logic [KEY_W-1:0] lock_q [NUM_GRAN];

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n) lock_q[g] <= '0;
      else if ((we && wr_idx == GIDX_W'(g)) || (we2 && wr_idx2 == GIDX_W'(g)))
        lock_q[g] <= wr_lock;
    end
  end

  assign rd_lock = lock_q[rd_idx];
endmodule

// File: rtl/tmc_data_store.sv
module tmc_data_store #(
  parameter int NUM_GRAN = 16,
  parameter int GRAN_B   = 16,
  parameter int DATA_W   = 8,
  localparam int GIDX_W  = $clog2(NUM_GRAN),
  localparam int BIDX_W  = $clog2(GRAN_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GIDX_W-1:0] gidx,
  input  logic [GIDX_W-1:0] gidx2,
  input  logic [BIDX_W-1:0] bidx,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              zero,
  input  logic              zero2
);
  logic [DATA_W-1:0] mem_q [NUM_GRAN][GRAN_B];

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
    logic clr;
    assign clr = (zero && gidx == GIDX_W'(g)) || (zero2 && gidx2 == GIDX_W'(g));
    for (genvar b = 0; b < GRAN_B; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n || clr) mem_q[g][b] <= '0;
        else if (we && gidx == GIDX_W'(g) && bidx == BIDX_W'(b))
          mem_q[g][b] <= wdata;
      end
    end
  end

  assign rdata = mem_q[gidx][bidx];
endmodule

// File: rtl/tmc_key_check.sv
module tmc_key_check
  import tagchk_pkg::*;
#(
  parameter int KW = 4
) (
  input  logic          check_en,
  input  logic          access,
  input  op_e           op,
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] lock,
  output logic          mismatch,
  output logic          fault
);
  function automatic logic keys_differ(logic [KW-1:0] k, logic [KW-1:0] l);
    return k != l;
  endfunction

  assign mismatch = keys_differ(key, lock);
  assign fault    = access && check_en && op_is_data(op) && mismatch;
endmodule

// File: rtl/tagchk_mem.sv
module tagchk_mem
  import tagchk_pkg::*;
#(
  parameter int NUM_GRAN = 16,
  parameter int GRAN_B   = 16,
  localparam int GIDX_W  = $clog2(NUM_GRAN),
  localparam int BIDX_W  = $clog2(GRAN_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_en,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault
);
  function automatic logic [KEY_W-1:0] key_of(logic [ADDR_W-1:0] a);
    return a[KEY_LSB +: KEY_W];
  endfunction

  function automatic logic [GIDX_W-1:0] gran_of(logic [ADDR_W-1:0] a);
    return a[BIDX_W +: GIDX_W];
  endfunction

  function automatic logic [GIDX_W-1:0] next_gran(logic [GIDX_W-1:0] g);
    return (g == GIDX_W'(NUM_GRAN - 1)) ? '0 : g + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] with_key(logic [ADDR_W-1:0] a, logic [KEY_W-1:0] k);
    logic [ADDR_W-1:0] r;
    r = a;
    r[KEY_LSB +: KEY_W] = k;
    return r;
  endfunction

  op_e               op;
  logic [KEY_W-1:0]  key, lock_rd;
  logic [GIDX_W-1:0] gidx, gidx2;
  logic [BIDX_W-1:0] bidx;
  logic [DATA_W-1:0] mem_rd;
  logic              key_mismatch, chk_fault;
  logic              data_we, lock_we, lock_we2, zero_we, zero_we2;

  assign op    = op_e'(req_op);
  assign key   = key_of(req_addr);
  assign gidx  = gran_of(req_addr);
  assign gidx2 = next_gran(gidx);
  assign bidx  = req_addr[BIDX_W-1:0];

  tmc_key_check #(.KW(KEY_W)) u_chk (
    .check_en (check_en),
    .access   (req_valid),
    .op       (op),
    .key      (key),
    .lock     (lock_rd),
    .mismatch (key_mismatch),
    .fault    (chk_fault)
  );

  assign data_we  = req_valid && !chk_fault && ((op == OP_STORE) || (op == OP_TAG_DATA));
  assign lock_we  = req_valid && !chk_fault && op_sets_lock(op);
  assign lock_we2 = lock_we && op_is_double(op);
  assign zero_we  = lock_we && op_zeroes(op);
  assign zero_we2 = zero_we && op_is_double(op);

  tmc_lock_store #(.NUM_GRAN(NUM_GRAN), .KEY_W(KEY_W)) u_locks (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (gidx),
    .rd_lock (lock_rd),
    .we      (lock_we),
    .we2     (lock_we2),
    .wr_idx  (gidx),
    .wr_idx2 (gidx2),
    .wr_lock (key)
  );

  tmc_data_store #(.NUM_GRAN(NUM_GRAN), .GRAN_B(GRAN_B), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .gidx  (gidx),
    .gidx2 (gidx2),
    .bidx  (bidx),
    .rdata (mem_rd),
    .we    (data_we),
    .wdata (req_wdata),
    .zero  (zero_we),
    .zero2 (zero_we2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= chk_fault;
      rsp_rdata <= (req_valid && op == OP_LOAD && !chk_fault) ? mem_rd : '0;
      rsp_addr  <= (op == OP_TAG_RD) ? with_key(req_addr, lock_rd) : req_addr;
    end
  end
endmodule

// File: rtl/tagchk_mem_sva.sv
module tagchk_mem_sva
  import tagchk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              check_en,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic              chk_fault,
  input logic              data_we,
  input logic              lock_we
);
  localparam logic [2:0] LD = 3'd0;
  localparam logic [2:0] ST = 3'd1;
  localparam logic [2:0] TR = 3'd2;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));

  p_fault_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (!data_we && !lock_we));

  p_fault_zero_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_rdata == '0));

  p_unchecked_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !check_en) |=> !rsp_fault);

  p_tag_ops_never_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != LD && req_op != ST) |=> !rsp_fault);

  p_tagrd_keeps_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == TR) |=>
      (rsp_addr[ADDR_W-1:KEY_LSB+KEY_W] == $past(req_addr[ADDR_W-1:KEY_LSB+KEY_W]) &&
       rsp_addr[KEY_LSB-1:0] == $past(req_addr[KEY_LSB-1:0])));

  p_non_load_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != LD) |=> (rsp_rdata == '0));
endmodule

bind tagchk_mem tagchk_mem_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .check_en  (check_en),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .chk_fault (chk_fault),
  .data_we   (data_we),
  .lock_we   (lock_we)
);

// File: tb/sim_tagchk_mem.sv
module sim_tagchk_mem;
  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        check_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [63:0] rsp_addr;
  logic        rsp_fault;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] mem_m [256];
  logic [3:0] lock_m [16];

  tagchk_mem u0 (
    .clk(clk), .rst_n(rst_n), .check_en(check_en), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault)
  );

  always #(CLK/2) clk = ~clk;

  function automatic logic [63:0] mk(logic [3:0] k, int i);
    return {4'h0, k, 48'h0, 8'(i)};
  endfunction

  task automatic req(input logic [2:0] op, input logic [63:0] a,
                     input logic [7:0] wd, input string tg);
    int g, b, g2;
    logic flt;
    logic [7:0] erd;
    logic [63:0] ea;
    g   = int'(a[7:4]);
    b   = int'(a[3:0]);
    g2  = (g + 1) % 16;
    flt = check_en && (op <= 3'd1) && (a[59:56] != lock_m[g]);
    erd = (op == 3'd0 && !flt) ? mem_m[g*16+b] : 8'h00;
    ea  = a;
    if (op == 3'd2) ea[59:56] = lock_m[g];
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(posedge clk);
    #(CLK/2);
    n_vec++;
    if (rsp_valid !== 1'b1 || rsp_fault !== flt || rsp_rdata !== erd || rsp_addr !== ea) begin
      n_bad++;
      $display("FAIL %s op=%0d addr=%h: valid=%b fault=%b rdata=%h raddr=%h expected fault=%b rdata=%h raddr=%h",
               tg, op, a, rsp_valid, rsp_fault, rsp_rdata, rsp_addr, flt, erd, ea);
    end
    if (op == 3'd1 && !flt) mem_m[g*16+b] = wd;
    if (op >= 3'd3) lock_m[g] = a[59:56];
    if (op == 3'd5 || op == 3'd6) lock_m[g2] = a[59:56];
    if (op == 3'd4 || op == 3'd6) for (int j = 0; j < 16; j++) mem_m[g*16+j] = 8'h00;
    if (op == 3'd6) for (int j = 0; j < 16; j++) mem_m[g2*16+j] = 8'h00;
    if (op == 3'd7) mem_m[g*16+b] = wd;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    for (int g = 0; g < 16; g++) lock_m[g] = 4'h0;
    repeat (3) @(posedge clk);
    #(CLK/2);
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 rsp_valid in reset=%b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    check_en = 1'b1;

    // R1: reset contents, key 0 passes
    for (int i = 0; i < 256; i++) req(3'd0, mk(4'h0, i), 8'h00, "R1");
    // R2: store and reload pattern
    for (int i = 0; i < 256; i++) req(3'd1, mk(4'h0, i), 8'(i * 7 + 3), "R2");
    for (int i = 0; i < 256; i++) req(3'd0, mk(4'h0, i), 8'h00, "R2");
    // R2: idle cycle gives no response
    @(posedge clk); #(CLK/2);
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 idle rsp_valid=%b expected 0", rsp_valid);
    end
    // R6: set distinct locks, R10: read them back with a wrong key
    for (int g = 0; g < 16; g++) req(3'd3, mk(4'((g * 3 + 1) % 16), g * 16), 8'h00, "R6");
    for (int g = 0; g < 16; g++) req(3'd2, mk(~lock_m[g], g * 16 + 5), 8'h00, "R10");
    for (int i = 0; i < 256; i++) req(3'd0, mk(lock_m[i / 16], i), 8'h00, "R6");
    // R3: mismatched loads and stores
    for (int i = 0; i < 256; i++) begin
      req(3'd0, mk(lock_m[i / 16] ^ 4'h9, i), 8'h00, "R3");
      req(3'd1, mk(lock_m[i / 16] ^ 4'h1, i), 8'hEE, "R3");
      req(3'd0, mk(lock_m[i / 16], i), 8'h00, "R3");
    end
    // R4: checking disabled
    check_en = 1'b0;
    for (int i = 0; i < 256; i += 3) begin
      req(3'd1, mk(lock_m[i / 16] ^ 4'h6, i), 8'(i ^ 8'h5A), "R4");
      req(3'd0, mk(lock_m[i / 16] ^ 4'hF, i), 8'h00, "R4");
    end
    check_en = 1'b1;
    for (int i = 0; i < 256; i += 3) req(3'd0, mk(lock_m[i / 16], i), 8'h00, "R4");
    // R5: ignored address bits
    for (int i = 0; i < 256; i += 5) begin
      req(3'd0, {4'hF, lock_m[i / 16], 48'h5A5A_0F0F_3C3C, 8'(i)}, 8'h00, "R5");
      req(3'd0, {4'h6, lock_m[i / 16], 48'hFFFF_FFFF_FFFF, 8'(i)}, 8'h00, "R5");
    end
    // R7: zeroing tag set on granule 3
    req(3'd4, mk(4'h7, 3 * 16 + 9), 8'h00, "R7");
    for (int i = 32; i < 80; i++) req(3'd0, mk(lock_m[i / 16], i), 8'h00, "R7");
    // R8: two-granule forms, wrap from granule 15 to 0
    req(3'd5, mk(4'hC, 15 * 16), 8'h00, "R8");
    req(3'd2, mk(4'h0, 15 * 16), 8'h00, "R8");
    req(3'd2, mk(4'h0, 0), 8'h00, "R8");
    req(3'd2, mk(4'h0, 14 * 16), 8'h00, "R8");
    for (int i = 0; i < 16; i++) req(3'd0, mk(4'hC, i), 8'h00, "R8");
    req(3'd6, mk(4'h2, 8 * 16 + 1), 8'h00, "R8");
    for (int i = 7 * 16; i < 11 * 16; i++) req(3'd0, mk(lock_m[i / 16], i), 8'h00, "R8");
    req(3'd6, mk(4'hD, 15 * 16 + 2), 8'h00, "R8");
    for (int i = 0; i < 16; i++) req(3'd0, mk(4'hD, i), 8'h00, "R8");
    // R9: combined tag-and-data store
    req(3'd7, mk(4'hB, 5 * 16 + 6), 8'h77, "R9");
    req(3'd2, mk(4'h0, 5 * 16), 8'h00, "R9");
    for (int i = 80; i < 96; i++) req(3'd0, mk(4'hB, i), 8'h00, "R9");
    // R10: tag operations with any key never fault
    for (int k = 0; k < 16; k++) req(3'd2, mk(4'(k), 10 * 16 + k), 8'h00, "R10");
    finish_run();
  end
endmodule